// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction fetch address of a small 4-bit controller, together with a shallow return stack. The address is split into a page field in the upper bits and an in-page offset in the lower bits. With the default widths that is a 4-bit page and a 6-bit offset, so 16 pages of 64 words each. The instruction decoder drives one-hot control strobes: step, skip, short jump, short call, long jump, long call and return. It also drives a 6-bit short target and a 10-bit long target. The block registers the resulting next address.

Short branches replace only the offset and leave the page as it is. Long branches load the whole address. A call pushes the address after the current one onto a two-level stack. A third nested call silently drops the oldest return address. A return pops the top level and refills it from the deeper level. The deeper level keeps its value, so returns beyond the stack depth keep yielding the same address.

A long jump or long call occupies two instruction words. The decoder steps past the first word and raises the long strobe while the fetch address points at the second word, with the full 10-bit target assembled on `tgt_long_i`. The return address of a long call is therefore the word after the second word. A skip request squashes the current slot: the slot becomes a plain advance.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `fetch_addr_o`, `stk_top_o` and `stk_deep_o` are all 000h. The reset is asserted asynchronously and released synchronously.
- R2: A cycle with only `step_i` high increments `fetch_addr_o` by one. The increment wraps from 3FFh to 000h. A cycle with no strobe high holds the address. Every change is visible right after the clock edge that samples the strobe.
- R3: A short jump sets bits [5:0] of the address to `tgt_short_i`. Bits [9:6], the page, are unchanged. The stack is unchanged.
- R4: A long jump loads all 10 bits from `tgt_long_i`. The stack is unchanged.
- R5: A short call pushes the current address plus one, with a 10-bit wrap (3FFh gives 000h). The old top level moves to the deep level. The offset is replaced as for a short jump.
- R6: A long call pushes the current address plus one in the same way as R5, and loads all 10 bits from `tgt_long_i`.
- R7: After three nested calls, the stack holds only the two most recent return addresses, and the first one is lost.
- R8: A return loads the address from the top level, copies the deep level into the top level and leaves the deep level unchanged. Further returns therefore keep yielding the deep level's value.
- R9: When `skip_i` is high, every other strobe and target in that cycle is ignored. The address advances by one and both stack levels stay the same.
- R10: When several strobes other than skip are high, exactly one acts, in this priority order: long call, long jump, short call, short jump, return, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released after two clock edges |
| step_i | input | 1 | Sequential advance strobe |
| skip_i | input | 1 | Squash the current slot; advance by one only |
| jmp_short_i | input | 1 | In-page jump strobe |
| call_short_i | input | 1 | In-page call strobe |
| jmp_long_i | input | 1 | Full-range jump strobe (second word of the instruction) |
| call_long_i | input | 1 | Full-range call strobe (second word of the instruction) |
| ret_i | input | 1 | Return strobe |
| tgt_short_i | input | 6 | Offset target for short branches |
| tgt_long_i | input | 10 | Full target for long branches |
| fetch_addr_o | output | 10 | Current fetch address |
| stk_top_o | output | 10 | Stack top level (most recent return address) |
| stk_deep_o | output | 10 | Stack deep level |

## Verification
Short branches are run from a non-zero page with targets at both offset extremes. This separates offset-only loading from full loading and from page corruption. Calls are made from a page's last word and from 3FFh, which separates a correct 10-bit return increment from an offset-only increment. A chain of three calls followed by four returns exposes both the overflow drop and the underflow repeat of the deep level. Cycles that combine skip with branch strobes, and cycles with several strobes high at once, pin down the priority order and show that a squashed slot leaves the stack untouched.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_SKIP,
    ACT_JS,
    ACT_CS,
    ACT_JL,
    ACT_CL,
    ACT_RET
  } act_e;
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_decide.sv
module pcs_decide
  import pcs_pkg::*;
(
  input  logic step_i,
  input  logic skip_i,
  input  logic jmp_short_i,
  input  logic call_short_i,
  input  logic jmp_long_i,
  input  logic call_long_i,
  input  logic ret_i,
  output act_e act_o
);
  // Squash first, then fixed priority among the branch strobes.
  always_comb begin
    if (skip_i)            act_o = ACT_SKIP;
    else if (call_long_i)  act_o = ACT_CL;
    else if (jmp_long_i)   act_o = ACT_JL;
    else if (call_short_i) act_o = ACT_CS;
    else if (jmp_short_i)  act_o = ACT_JS;
    else if (ret_i)        act_o = ACT_RET;
    else if (step_i)       act_o = ACT_STEP;
    else                   act_o = ACT_HOLD;
  end
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 6,
  localparam int AW    = PAGE_W + OFF_W
) (
  input  act_e            act_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [OFF_W-1:0] tgt_short_i,
  input  logic [AW-1:0]   tgt_long_i,
  input  logic [AW-1:0]   stk_top_i,
  output logic [AW-1:0]   addr_o,
  output logic [AW-1:0]   ret_addr_o,
  output logic            push_o,
  output logic            pop_o
);
  logic [AW-1:0]  inc;
  logic [AW-1:0]  in_page;

  assign inc        = addr_i + {{(AW-1){1'b0}}, 1'b1};
  assign in_page    = {addr_i[AW-1:OFF_W], tgt_short_i};
  assign ret_addr_o = inc;

  always_comb begin
    addr_o = addr_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    unique case (act_i)
      ACT_STEP, ACT_SKIP: addr_o = inc;
      ACT_JS:             addr_o = in_page;
      ACT_CS: begin
        addr_o = in_page;
        push_o = 1'b1;
      end
      ACT_JL:             addr_o = tgt_long_i;
      ACT_CL: begin
        addr_o = tgt_long_i;
        push_o = 1'b1;
      end
      ACT_RET: begin
        addr_o = stk_top_i;
        pop_o  = 1'b1;
      end
      default:            addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_val_i,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] deep_o
);
  logic [AW-1:0] lvl_q [DEPTH];
  logic [AW-1:0] lvl_d [DEPTH];
  logic          en;

  assign en = push_i | pop_i;

  // Push shifts toward the deep end, dropping the last level; pop shifts
  // toward the top and leaves the deepest level as it was.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      lvl_d[i] = lvl_q[i];
      if (push_i) begin
        if (i == 0) lvl_d[i] = push_val_i;
        else        lvl_d[i] = lvl_q[(i > 0) ? i - 1 : 0];
      end else if (pop_i) begin
        if (i < DEPTH - 1) lvl_d[i] = lvl_q[(i < DEPTH - 1) ? i + 1 : i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= lvl_d[i];
    end
  end

  assign top_o  = lvl_q[0];
  assign deep_o = lvl_q[DEPTH-1];

  // R8: the deepest level survives a pop
  p_deep_kept_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (deep_o == $past(deep_o)));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 6,
  parameter int DEPTH  = 2,
  localparam int AW    = PAGE_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             skip_i,
  input  logic             jmp_short_i,
  input  logic             call_short_i,
  input  logic             jmp_long_i,
  input  logic             call_long_i,
  input  logic             ret_i,
  input  logic [OFF_W-1:0] tgt_short_i,
  input  logic [AW-1:0]    tgt_long_i,
  output logic [AW-1:0]    fetch_addr_o,
  output logic [AW-1:0]    stk_top_o,
  output logic [AW-1:0]    stk_deep_o
);
  logic          rst_ni;
  act_e          act;
  logic [AW-1:0] addr_q, addr_d, ret_addr;
  logic          push, pop, addr_en;

  pcs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_no(rst_ni)
  );

  pcs_decide u_dec (
    .step_i(step_i), .skip_i(skip_i), .jmp_short_i(jmp_short_i),
    .call_short_i(call_short_i), .jmp_long_i(jmp_long_i),
    .call_long_i(call_long_i), .ret_i(ret_i), .act_o(act)
  );

  pcs_next #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_next (
    .act_i(act), .addr_i(addr_q), .tgt_short_i(tgt_short_i),
    .tgt_long_i(tgt_long_i), .stk_top_i(stk_top_o), .addr_o(addr_d),
    .ret_addr_o(ret_addr), .push_o(push), .pop_o(pop)
  );

  pcs_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_val_i(ret_addr), .top_o(stk_top_o), .deep_o(stk_deep_o)
  );

  assign addr_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign fetch_addr_o = addr_q;

  // R1
  always @(posedge clk) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (addr_q == '0 && stk_top_o == '0 && stk_deep_o == '0);
    end
  end

  // R2
  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (act == ACT_STEP) |=> (fetch_addr_o == AW'($past(fetch_addr_o) + 1'b1)));

  // R3
  p_short_page_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (act == ACT_JS) |=> (fetch_addr_o[AW-1:OFF_W] == $past(fetch_addr_o[AW-1:OFF_W])
                         && fetch_addr_o[OFF_W-1:0] == $past(tgt_short_i)
                         && $stable(stk_top_o)));

  // R4
  p_long_load_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (act == ACT_JL) |=> (fetch_addr_o == $past(tgt_long_i) && $stable(stk_deep_o)));

  // R5 / R6 / R7
  p_call_push_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (act == ACT_CS || act == ACT_CL) |=>
      (stk_top_o == AW'($past(fetch_addr_o) + 1'b1) && stk_deep_o == $past(stk_top_o)));

  // R8
  p_ret_pop_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (act == ACT_RET) |=> (fetch_addr_o == $past(stk_top_o) && stk_top_o == $past(stk_deep_o)));

  // R9
  p_skip_squash_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    skip_i |=> (fetch_addr_o == AW'($past(fetch_addr_o) + 1'b1)
                && $stable(stk_top_o) && $stable(stk_deep_o)));
endmodule

// File: tb/pc_stack_unit_test.sv
module pc_stack_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_i, skip_i, jmp_short_i, call_short_i, jmp_long_i, call_long_i, ret_i;
  logic [5:0] tgt_short_i;
  logic [9:0] tgt_long_i;
  logic [9:0] fetch_addr_o, stk_top_o, stk_deep_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [9:0] e_a, e_t, e_d;

  always #2.5 clk = ~clk;

  pc_stack_unit uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .skip_i(skip_i),
    .jmp_short_i(jmp_short_i), .call_short_i(call_short_i),
    .jmp_long_i(jmp_long_i), .call_long_i(call_long_i), .ret_i(ret_i),
    .tgt_short_i(tgt_short_i), .tgt_long_i(tgt_long_i),
    .fetch_addr_o(fetch_addr_o), .stk_top_o(stk_top_o), .stk_deep_o(stk_deep_o)
  );

  task automatic check(string tag);
    n_chk++;
    if (fetch_addr_o !== e_a || stk_top_o !== e_t || stk_deep_o !== e_d) begin
      n_fail++;
      $display("FAIL %s: addr/top/deep actual %h/%h/%h expected %h/%h/%h",
               tag, fetch_addr_o, stk_top_o, stk_deep_o, e_a, e_t, e_d);
    end
  endtask

  // Drive one cycle (strobe bits: sk, cl, jl, cs, js, rt, st), update the model, check.
  task automatic cyc(bit sk, bit cl, bit jl, bit cs, bit js, bit rt, bit st,
                     logic [5:0] ts, logic [9:0] tl, string tag);
    @(negedge clk);
    skip_i = sk; call_long_i = cl; jmp_long_i = jl; call_short_i = cs;
    jmp_short_i = js; ret_i = rt; step_i = st; tgt_short_i = ts; tgt_long_i = tl;
    if (sk)      e_a = e_a + 10'd1;
    else if (cl) begin e_d = e_t; e_t = e_a + 10'd1; e_a = tl; end
    else if (jl) e_a = tl;
    else if (cs) begin e_d = e_t; e_t = e_a + 10'd1; e_a = {e_a[9:6], ts}; end
    else if (js) e_a = {e_a[9:6], ts};
    else if (rt) begin e_a = e_t; e_t = e_d; end
    else if (st) e_a = e_a + 10'd1;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    {step_i, skip_i, jmp_short_i, call_short_i, jmp_long_i, call_long_i, ret_i} = '0;
    tgt_short_i = '0; tgt_long_i = '0;
    e_a = '0; e_t = '0; e_d = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after release");
  endtask

  task automatic t_step_wrap;
    cyc(0,0,1,0,0,0,0, 6'h00, 10'h3FE, "R4 long jump to 3FE");
    cyc(0,0,0,0,0,0,1, 6'h00, 10'h000, "R2 step to 3FF");
    cyc(0,0,0,0,0,0,1, 6'h00, 10'h000, "R2 wrap to 000");
    cyc(0,0,0,0,0,0,0, 6'h15, 10'h2AA, "R2 hold with no strobe");
  endtask

  task automatic t_short_jump;
    cyc(0,0,1,0,0,0,0, 6'h00, 10'h15A, "R4 long jump to page 5");
    cyc(0,0,0,0,1,0,0, 6'h3F, 10'h000, "R3 short to offset 3F");
    cyc(0,0,0,0,1,0,0, 6'h00, 10'h3FF, "R3 short to offset 00");
  endtask

  task automatic t_calls;
    cyc(0,0,1,0,0,0,0, 6'h00, 10'h0BF, "R4 long jump to page end");
    cyc(0,0,0,1,0,0,0, 6'h05, 10'h000, "R5 short call from 0BF");
    cyc(0,1,0,0,0,0,0, 6'h00, 10'h3FF, "R6 long call to 3FF");
    cyc(0,0,0,1,0,0,0, 6'h11, 10'h000, "R7 third call wraps push to 000");
    cyc(0,0,0,0,0,1,0, 6'h00, 10'h000, "R8 first return");
    cyc(0,0,0,0,0,1,0, 6'h00, 10'h000, "R8 second return");
    cyc(0,0,0,0,0,1,0, 6'h00, 10'h000, "R8 underflow return");
    cyc(0,0,0,0,0,1,0, 6'h00, 10'h000, "R8 underflow repeat");
  endtask

  task automatic t_skip;
    cyc(0,0,1,0,0,0,0, 6'h00, 10'h210, "R4 long jump to 210");
    cyc(0,0,0,1,0,0,0, 6'h22, 10'h000, "R5 call to load stack");
    cyc(1,1,1,1,1,1,1, 6'h33, 10'h123, "R9 skip with all strobes");
    cyc(1,0,0,0,0,1,0, 6'h00, 10'h000, "R9 skip with return");
    cyc(1,0,0,1,0,0,0, 6'h01, 10'h000, "R9 skip with short call");
  endtask

  task automatic t_priority;
    cyc(0,1,1,1,1,1,1, 6'h07, 10'h345, "R10 long call wins");
    cyc(0,0,1,1,1,1,1, 6'h07, 10'h111, "R10 long jump over short call");
    cyc(0,0,0,1,1,1,1, 6'h2C, 10'h000, "R10 short call over short jump");
    cyc(0,0,0,0,1,1,1, 6'h09, 10'h000, "R10 short jump over return");
    cyc(0,0,0,0,0,1,1, 6'h00, 10'h000, "R10 return over step");
  endtask

  initial begin
    t_reset();
    t_step_wrap();
    t_short_jump();
    t_calls();
    t_skip();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule